// File: doc/BRIEF.md
# Charge and Power-Path Supervisor

This block keeps the battery charge selection and the power-source selection that a host writes over a serial link, and turns them into switch enable lines. A charge enable reaches a battery only while the input supply is reported sufficient. The selection also lapses on its own if the host stops refreshing it. Either battery, or both together, may be charged. Any mix of sources, including both batteries at once, may be routed to the system load.

When the system rail falls below its low-power threshold, the block takes the switches away from the host without waiting for software. It turns on every output-side switch, closes the input-side switch of whichever source is actually delivering power, and latches a three-diode status flag. The host polls that flag, reprograms the source selection, and the write clears the flag. All comparator flags arrive asynchronously and pass through two flip-flops before any logic uses them.

Top module: `chgpath_supervisor`

## Requirements
- R1: During and right after reset, every output is 0: charge enables, charge-select status, both switch vectors and the diode flag.
- R2: `chgEn[i]` equals charge-select bit i ANDed with the synchronised supply-good flag. Dropping the flag removes the enables but keeps the selection, and the enables come back when the flag returns.
- R3: A charge write of 2'b11 selects both batteries (bit 0 battery A, bit 1 battery B) and enables both at once.
- R4: After a charge write on clock edge t, the selection is cleared on edge t+WD_CYCLES unless another charge write comes first. Each charge write reloads the full period.
- R5: With low-power inactive, `inSwEn` and `outSwEn` both equal the stored source selection, with bit 0 the DC input, bit 1 battery A and bit 2 battery B. Several bits may be set together.
- R6: Two clock edges after the raw low-power flag rises, `outSwEn` is all ones and stays all ones while the flag is high.
- R7: While low-power is active, `inSwEn` equals the synchronised supplying-source flags, using the bit order of R5.
- R8: `diodeMode` sets one edge after low-power is seen in synchronised form. It stays set after low-power ends, and the switches then return to the stored selection.
- R9: A source-selection write clears `diodeMode` only while low-power is inactive. A write made during low-power is stored but does not clear the flag.
- R10: A change on any raw flag input has no effect on the outputs after one clock edge and takes effect after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chgWrEn | input | 1 | Charge-select write strobe |
| chgWrData | input | NUM_BAT | Charge-select bits (bit 0 battery A, bit 1 battery B) |
| pathWrEn | input | 1 | Source-selection write strobe |
| pathWrData | input | NUM_BAT+1 | Source bits (bit 0 DC input, then batteries) |
| adapterOkRaw | input | 1 | Asynchronous supply-sufficient flag |
| lowPwrRaw | input | 1 | Asynchronous low-system-voltage flag |
| supplyRaw | input | NUM_BAT+1 | Asynchronous flags marking the source delivering power |
| chgEn | output | NUM_BAT | Charge switch enables |
| chgSelStatus | output | NUM_BAT | Current charge selection, for host readback |
| inSwEn | output | NUM_BAT+1 | Input-side switch enables |
| outSwEn | output | NUM_BAT+1 | Output-side switch enables |
| diodeMode | output | 1 | Latched three-diode status flag |

## Verification
The checker confirms on every cycle that charge enables never appear without the supply-good flag or outside the selection, and that low-power forces every output switch on. It also confirms that the diode flag sets after low-power, holds until a selection write, and that the input and output switches agree outside low-power. The exact watchdog expiry edge, reload on refresh, the two-edge synchroniser delay, and the order of write and low-power events depend on stimulus history. Only the bench scenarios, compared against an independent cycle model, show those.

// File: rtl/chgpath_pkg.sv
package chgpath_pkg;
  // Strobes from the control half to the datapath half, one cycle each.
  typedef struct packed {
    logic loadChg;
    logic expireChg;
    logic loadPath;
    logic setDiode;
    logic clearDiode;
  } ctrlStrobes_t;
endpackage

// File: rtl/chgpath_sync.sv
module chgpath_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [1:0] stages;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stages <= '0;
      else        stages <= {stages[0], din[b]};
    end
    assign dout[b] = stages[1];
  end
endmodule

// File: rtl/chgpath_ctrl.sv
module chgpath_ctrl
  import chgpath_pkg::*;
#(
  parameter int WD_CYCLES = 1000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chgWrEn,
  input  logic         pathWrEn,
  input  logic         lowPwrSync,
  output ctrlStrobes_t strobes,
  output logic         wdZero
);
  localparam int CNT_W = (WD_CYCLES > 2) ? $clog2(WD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WD_CYCLES - 1);

  logic [CNT_W-1:0] wdCnt;

  // Refresh countdown: reload on every charge write, rest at zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             wdCnt <= '0;
    else if (chgWrEn)       wdCnt <= RELOAD;
    else if (wdCnt != '0)   wdCnt <= wdCnt - 1'b1;
  end

  assign wdZero = (wdCnt == '0);

  always_comb begin
    strobes.loadChg    = chgWrEn;
    strobes.expireChg  = !chgWrEn && wdZero;
    strobes.loadPath   = pathWrEn;
    strobes.setDiode   = lowPwrSync;             // set wins over clear
    strobes.clearDiode = pathWrEn && !lowPwrSync;
  end
endmodule

// File: rtl/chgpath_datapath.sv
module chgpath_datapath
  import chgpath_pkg::*;
#(
  parameter int NUM_BAT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobes_t       strobes,
  input  logic [NUM_BAT-1:0] chgWrData,
  input  logic [NUM_BAT:0]   pathWrData,
  input  logic               adapterOkSync,
  input  logic               lowPwrSync,
  input  logic [NUM_BAT:0]   supplySync,
  output logic [NUM_BAT-1:0] chgEn,
  output logic [NUM_BAT-1:0] chgSelStatus,
  output logic [NUM_BAT:0]   inSwEn,
  output logic [NUM_BAT:0]   outSwEn,
  output logic               diodeMode
);
  localparam int NUM_SRC = NUM_BAT + 1;

  logic [NUM_BAT-1:0] chgSel;
  logic [NUM_SRC-1:0] pathSel;
  logic               diodeFlag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 chgSel <= '0;
    else if (strobes.loadChg)   chgSel <= chgWrData;
    else if (strobes.expireChg) chgSel <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pathSel <= '0;
    else if (strobes.loadPath) pathSel <= pathWrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  diodeFlag <= 1'b0;
    else if (strobes.setDiode)   diodeFlag <= 1'b1;
    else if (strobes.clearDiode) diodeFlag <= 1'b0;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign outSwEn[s] = lowPwrSync | pathSel[s];
    assign inSwEn[s]  = lowPwrSync ? supplySync[s] : pathSel[s];
  end

  for (genvar b = 0; b < NUM_BAT; b++) begin : g_bat
    assign chgEn[b] = chgSel[b] & adapterOkSync;
  end

  assign chgSelStatus = chgSel;
  assign diodeMode    = diodeFlag;
endmodule

// File: rtl/chgpath_supervisor.sv
module chgpath_supervisor
  import chgpath_pkg::*;
#(
  parameter int NUM_BAT   = 2,
  parameter int WD_CYCLES = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chgWrEn,
  input  logic [NUM_BAT-1:0] chgWrData,
  input  logic               pathWrEn,
  input  logic [NUM_BAT:0]   pathWrData,
  input  logic               adapterOkRaw,
  input  logic               lowPwrRaw,
  input  logic [NUM_BAT:0]   supplyRaw,
  output logic [NUM_BAT-1:0] chgEn,
  output logic [NUM_BAT-1:0] chgSelStatus,
  output logic [NUM_BAT:0]   inSwEn,
  output logic [NUM_BAT:0]   outSwEn,
  output logic               diodeMode
);
  localparam int SYNC_W = NUM_BAT + 3;

  logic [SYNC_W-1:0] flagSync;
  logic              adapterOkSync;
  logic              lowPwrSync;
  logic [NUM_BAT:0]  supplySync;
  ctrlStrobes_t      strobes;
  logic              wdZero;

  chgpath_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({supplyRaw, lowPwrRaw, adapterOkRaw}),
    .dout (flagSync)
  );

  assign adapterOkSync = flagSync[0];
  assign lowPwrSync    = flagSync[1];
  assign supplySync    = flagSync[SYNC_W-1:2];

  chgpath_ctrl #(.WD_CYCLES(WD_CYCLES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .chgWrEn   (chgWrEn),
    .pathWrEn  (pathWrEn),
    .lowPwrSync(lowPwrSync),
    .strobes   (strobes),
    .wdZero    (wdZero)
  );

  chgpath_datapath #(.NUM_BAT(NUM_BAT)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .chgWrData    (chgWrData),
    .pathWrData   (pathWrData),
    .adapterOkSync(adapterOkSync),
    .lowPwrSync   (lowPwrSync),
    .supplySync   (supplySync),
    .chgEn        (chgEn),
    .chgSelStatus (chgSelStatus),
    .inSwEn       (inSwEn),
    .outSwEn      (outSwEn),
    .diodeMode    (diodeMode)
  );
endmodule

// File: rtl/chgpath_supervisor_chk.sv
module chgpath_supervisor_chk #(
  parameter int NUM_BAT = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               chgWrEn,
  input logic               pathWrEn,
  input logic [NUM_BAT-1:0] chgEn,
  input logic [NUM_BAT-1:0] chgSelStatus,
  input logic [NUM_BAT:0]   inSwEn,
  input logic [NUM_BAT:0]   outSwEn,
  input logic               diodeMode,
  input logic               lowPwrSync,
  input logic               adapterOkSync,
  input logic               wdZero
);
  // R2: no charge enable without supply-good, none outside the selection
  assert_chg_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chgEn != '0) |-> (adapterOkSync && ((chgEn & ~chgSelStatus) == '0)));

  // R4: an exhausted countdown without a refresh empties the selection
  assert_wd_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wdZero && !chgWrEn) |=> (chgSelStatus == '0));

  // R5: outside low-power both switch sides follow the same selection
  assert_path_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lowPwrSync |-> (inSwEn == outSwEn));

  // R6: low-power forces every output-side switch on
  assert_out_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lowPwrSync |-> (&outSwEn));

  // R8: the diode flag sets on the edge after low-power is seen
  assert_diode_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lowPwrSync |=> diodeMode);

  // R9: only a selection write can clear the diode flag
  assert_diode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (diodeMode && !pathWrEn) |=> diodeMode);
endmodule

bind chgpath_supervisor chgpath_supervisor_chk #(.NUM_BAT(NUM_BAT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .chgWrEn      (chgWrEn),
  .pathWrEn     (pathWrEn),
  .chgEn        (chgEn),
  .chgSelStatus (chgSelStatus),
  .inSwEn       (inSwEn),
  .outSwEn      (outSwEn),
  .diodeMode    (diodeMode),
  .lowPwrSync   (lowPwrSync),
  .adapterOkSync(adapterOkSync),
  .wdZero       (wdZero)
);

// File: tb/chgpath_supervisor_tb.sv
`timescale 1ns/1ps
module chgpath_supervisor_tb;
  localparam int NB = 2;
  localparam int WD = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chgWrEn = 1'b0;
  logic [NB-1:0] chgWrData = '0;
  logic pathWrEn = 1'b0;
  logic [NB:0] pathWrData = '0;
  logic adapterOkRaw = 1'b0;
  logic lowPwrRaw = 1'b0;
  logic [NB:0] supplyRaw = '0;
  logic [NB-1:0] chgEn, chgSelStatus;
  logic [NB:0] inSwEn, outSwEn;
  logic diodeMode;

  always #2 clk = ~clk;

  chgpath_supervisor #(.NUM_BAT(NB), .WD_CYCLES(WD)) u_dut (
    .clk(clk), .rst_n(rst_n), .chgWrEn(chgWrEn), .chgWrData(chgWrData),
    .pathWrEn(pathWrEn), .pathWrData(pathWrData), .adapterOkRaw(adapterOkRaw),
    .lowPwrRaw(lowPwrRaw), .supplyRaw(supplyRaw), .chgEn(chgEn),
    .chgSelStatus(chgSelStatus), .inSwEn(inSwEn), .outSwEn(outSwEn),
    .diodeMode(diodeMode)
  );

  typedef struct {
    logic [NB-1:0] chgEn;
    logic [NB-1:0] sel;
    logic [NB:0]   inSw;
    logic [NB:0]   outSw;
    logic          diode;
    string         tag;
  } item_t;

  item_t expQ[$];
  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  // Reference state built from the requirements
  logic [NB+2:0] mS1 = '0, mS2 = '0;  // {supply, low, adapterOk}
  int            mCnt = 0;
  logic [NB-1:0] mSel = '0;
  logic [NB:0]   mPath = '0;
  logic          mDiode = 1'b0;

  task automatic step(input logic cw, input logic [NB-1:0] cd,
                      input logic pw, input logic [NB:0] pd,
                      input logic ok, input logic lp, input logic [NB:0] sp,
                      input string tag);
    item_t it;
    logic  oldLow;
    @(negedge clk);
    chgWrEn = cw; chgWrData = cd; pathWrEn = pw; pathWrData = pd;
    adapterOkRaw = ok; lowPwrRaw = lp; supplyRaw = sp;
    oldLow = mS2[1];
    if (oldLow)  mDiode = 1'b1;
    else if (pw) mDiode = 1'b0;
    if (cw) begin mSel = cd; mCnt = WD - 1; end
    else if (mCnt == 0) mSel = '0;
    else mCnt--;
    if (pw) mPath = pd;
    mS2 = mS1;
    mS1 = {sp, lp, ok};
    it.sel   = mSel;
    it.chgEn = mSel & {NB{mS2[0]}};
    it.outSw = mS2[1] ? '1 : mPath;
    it.inSw  = mS2[1] ? mS2[NB+2:2] : mPath;
    it.diode = mDiode;
    it.tag   = tag;
    expQ.push_back(it);
  endtask

  // Monitor: pops one expectation per clock, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        item_t e;
        e = expQ.pop_front();
        checkCnt++;
        if (chgEn !== e.chgEn || chgSelStatus !== e.sel || inSwEn !== e.inSw ||
            outSwEn !== e.outSw || diodeMode !== e.diode) begin
          failCnt++;
          $display("FAIL %s: got chgEn=%b sel=%b in=%b out=%b diode=%b, expected chgEn=%b sel=%b in=%b out=%b diode=%b",
                   e.tag, chgEn, chgSelStatus, inSwEn, outSwEn, diodeMode,
                   e.chgEn, e.sel, e.inSw, e.outSw, e.diode);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkCnt++;  // R1 reset state
    if (chgEn !== '0 || chgSelStatus !== '0 || inSwEn !== '0 ||
        outSwEn !== '0 || diodeMode !== 1'b0) begin
      failCnt++;
      $display("FAIL R1: got chgEn=%b sel=%b in=%b out=%b diode=%b, expected all 0",
               chgEn, chgSelStatus, inSwEn, outSwEn, diodeMode);
    end
    @(negedge clk);
    rst_n = 1'b1;

    step(0, 2'b00, 0, 3'b000, 0, 0, 3'b000, "R1");
    // R10: selection made first, supply-good raised; enable appears on the second edge
    step(1, 2'b01, 0, 3'b000, 0, 0, 3'b000, "R2");
    step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R10");
    step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R10");
    step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R10");
    // R3: both batteries
    step(1, 2'b11, 0, 3'b000, 1, 0, 3'b000, "R3");
    step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R3");
    // R2: supply-good drop removes enables, keeps selection
    step(0, 2'b00, 0, 3'b000, 0, 0, 3'b000, "R2");
    step(0, 2'b00, 0, 3'b000, 0, 0, 3'b000, "R2");
    step(0, 2'b00, 0, 3'b000, 0, 0, 3'b000, "R2");
    step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R2");
    step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R2");
    step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R2");
    // R4: refresh every 8 cycles keeps selection, then let it expire
    for (int r = 0; r < 4; r++) begin
      step(1, 2'b10, 0, 3'b000, 1, 0, 3'b000, "R4");
      for (int k = 0; k < 7; k++) step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R4");
    end
    step(1, 2'b11, 0, 3'b000, 1, 0, 3'b000, "R4");
    for (int k = 0; k < WD + 3; k++) step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R4");
    // R5: source selections incl. both batteries
    step(0, 2'b00, 1, 3'b110, 1, 0, 3'b000, "R5");
    step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R5");
    step(0, 2'b00, 1, 3'b001, 1, 0, 3'b000, "R5");
    step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R5");
    // R6/R7: low-power with battery A supplying
    step(0, 2'b00, 0, 3'b000, 1, 1, 3'b010, "R6");
    step(0, 2'b00, 0, 3'b000, 1, 1, 3'b010, "R6");
    step(0, 2'b00, 0, 3'b000, 1, 1, 3'b010, "R7");
    step(0, 2'b00, 0, 3'b000, 1, 1, 3'b100, "R7");
    step(0, 2'b00, 0, 3'b000, 1, 1, 3'b100, "R7");
    step(0, 2'b00, 0, 3'b000, 1, 1, 3'b100, "R8");
    // R9: write during low-power is stored but flag stays
    step(0, 2'b00, 1, 3'b100, 1, 1, 3'b100, "R9");
    step(0, 2'b00, 0, 3'b000, 1, 1, 3'b100, "R9");
    // R8: low-power ends, flag holds, switches return to selection
    step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R8");
    step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R8");
    step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R8");
    step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R8");
    // R9: write with low-power inactive clears the flag
    step(0, 2'b00, 1, 3'b011, 1, 0, 3'b000, "R9");
    step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R9");
    // R10: single-cycle low-power pulse still shows after two edges
    step(0, 2'b00, 0, 3'b000, 1, 1, 3'b001, "R10");
    step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R10");
    step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R10");
    step(0, 2'b00, 0, 3'b000, 1, 0, 3'b000, "R10");

    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule